// File: doc/BRIEF.md
# Stream Stall Timeout Detector

This block watches one stream source and reports when its downstream sink has refused data for too long while the current transfer still has words left to move. A two-stage timer measures the stall. The first stage is a prescaler that divides the core clock. The second stage counts prescaled ticks. Both stages take 12-bit programmed values from the surrounding control registers. Those registers are expected to come out of reset holding 0xFFF for the divider and 0xFFE for the tick count.

The timer arms on the first cycle in which the enable bit is set, a transfer is pending and the sink is not ready. It then runs one-shot. On expiry it emits a single-cycle `timeout_evt` pulse, which the interrupt logic outside the block turns into a sticky status bit. The stall ends when the sink takes a word (`xfer_pending` and `sink_ready` both high), when nothing is pending any more, or when enable is cleared. Any of these cancels the count and allows a later stall to arm the timer again with a full interval.

The stream handshake follows valid/ready rules. `xfer_pending` acts as the source's valid and `sink_ready` is the sink's ready. A word moves only in a cycle where both are high. A cycle with valid high and ready low is back-pressure, and that is the condition the timer measures. Ready with nothing pending is not progress, but it still breaks the stall.

Top module: `stall_timeout`

## Requirements
- R1: After reset `timeout_evt` is low and stays low until a stall has lasted its full interval.
- R2: The timer arms only in a cycle where `tmo_enable`=1, `xfer_pending`=1 and `sink_ready`=0 all hold. With any of these conditions missing, no event is ever produced.
- R3: With divider value P and count value T, the arm cycle is followed by `max(T,1)*(P+1)` further stall cycles, and `timeout_evt` is high in the cycle after those. A count of 0 behaves as 1.
- R4: With P = 0 the timer ticks on every core clock, so the wait is `max(T,1)` stall cycles after the arm cycle.
- R5: A cycle with `xfer_pending`=1 and `sink_ready`=1 (a transfer) cancels a running count. The next stall arms the timer again with the full interval.
- R6: Clearing `tmo_enable` cancels a running count. No event is produced while it is clear.
- R7: A cycle with `xfer_pending`=0 cancels a running count.
- R8: `timeout_evt` is high for exactly one cycle. It fires at most once per unbroken stall, however long the stall lasts.
- R9: P and T are captured when the timer arms. Changing `pre_div` or `tmo_count` during a count does not change the interval until the timer is re-armed.
- R10: All 12-bit values are honoured without wrap, including P = 0xFFF and T = 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_enable | input | 1 | Timeout enable bit |
| pre_div | input | 12 | Prescaler value P; tick period is P+1 clocks |
| tmo_count | input | 12 | Number of prescaled ticks T to wait |
| xfer_pending | input | 1 | Transfer has words remaining (stream valid) |
| sink_ready | input | 1 | Downstream sink can accept a word (stream ready) |
| timeout_evt | output | 1 | One-cycle timeout event |

## Verification
The bench targets the following corner cases. Each failure mode it would catch is listed with its case.

- **Exact expiry cycle for several divider and count pairs.** An off-by-one in either stage shifts the pulse by one cycle or by a whole tick period.
- **A zero count and a zero divider.** Here a wrong design would either underflow into a 4096-tick wait or never fire.
- **Breaking a stall by a transfer, by dropping pending and by clearing enable, each just before expiry.** A design that only pauses, instead of restarting, fires early on the next stall.
- **Long stalls, reprogramming during a count, and the full 12-bit values.** A design without a one-shot guard fires repeatedly. A design that reads live values shifts its expiry. A narrow counter wraps.

// File: rtl/stall_timeout_pkg.sv
package stall_timeout_pkg;
  localparam int DEFAULT_FIELD_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_SPENT = 2'd2
  } tmo_state_e;
endpackage

// File: rtl/stall_prescaler.sv
module stall_prescaler #(
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               run,
  input  logic [FIELD_W-1:0] div_val,
  output logic               tick
);
  logic [FIELD_W-1:0] div_q;
  logic [FIELD_W-1:0] cnt_q;

  // A tick is produced in a running cycle where the countdown has reached zero.
  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= div_val;
      cnt_q <= div_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= div_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/stall_tick_counter.sv
module stall_tick_counter #(
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               tick,
  input  logic [FIELD_W-1:0] count_val,
  output logic               expire
);
  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  logic [FIELD_W-1:0] left_q;
  logic [FIELD_W-1:0] load_val;

  // A programmed count of zero is treated as a single tick.
  assign load_val = (count_val == '0) ? ONE : count_val;
  assign expire   = tick && (left_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (load)  left_q <= load_val;
    else if (tick && left_q != '0) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/stall_arm_ctrl.sv
module stall_arm_ctrl
  import stall_timeout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  input  logic expire,
  output logic load,
  output logic run,
  output logic evt
);
  tmo_state_e state_q, state_d;

  assign load = stall && (state_q == ST_IDLE);
  assign run  = stall && (state_q == ST_COUNT);

  always_comb begin
    state_d = state_q;
    if (!stall) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_COUNT;
        ST_COUNT: if (expire) state_d = ST_SPENT;
        ST_SPENT: state_d = ST_SPENT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      evt     <= 1'b0;
    end else begin
      state_q <= state_d;
      evt     <= run && expire;
    end
  end
endmodule

// File: rtl/stall_timeout.sv
module stall_timeout #(
  parameter int FIELD_W = stall_timeout_pkg::DEFAULT_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmo_enable,
  input  logic [FIELD_W-1:0] pre_div,
  input  logic [FIELD_W-1:0] tmo_count,
  input  logic               xfer_pending,
  input  logic               sink_ready,
  output logic               timeout_evt
);
  logic stall;
  logic load;
  logic run;
  logic tick;
  logic expire;

  // Back-pressure: the source holds a word but the sink refuses it.
  assign stall = tmo_enable && xfer_pending && !sink_ready;

  stall_arm_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .stall  (stall),
    .expire (expire),
    .load   (load),
    .run    (run),
    .evt    (timeout_evt)
  );

  stall_prescaler #(.FIELD_W(FIELD_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .run     (run),
    .div_val (pre_div),
    .tick    (tick)
  );

  stall_tick_counter #(.FIELD_W(FIELD_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .tick      (tick),
    .count_val (tmo_count),
    .expire    (expire)
  );
endmodule

// File: rtl/stall_timeout_chk.sv
module stall_timeout_chk (
  input logic clk,
  input logic rst_n,
  input logic tmo_enable,
  input logic xfer_pending,
  input logic sink_ready,
  input logic timeout_evt
);
  logic       stall_w;
  logic [7:0] run_len;
  logic [1:0] fires_in_run;

  assign stall_w = tmo_enable && xfer_pending && !sink_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len      <= '0;
      fires_in_run <= '0;
    end else if (!stall_w) begin
      run_len      <= '0;
      fires_in_run <= timeout_evt ? 2'd1 : 2'd0;
    end else begin
      if (run_len != 8'hFF) run_len <= run_len + 1'b1;
      if (timeout_evt && fires_in_run != 2'd3) fires_in_run <= fires_in_run + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rst_n) |-> !timeout_evt);

  // R2: an event is only possible right after a stalled cycle
  assert_evt_after_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> $past(stall_w));

  assert_transfer_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pending && sink_ready) |=> !timeout_evt);

  assert_disable_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_enable |=> !timeout_evt);

  assert_idle_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_pending |=> !timeout_evt);

  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !timeout_evt);

  assert_once_per_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && stall_w) |-> (fires_in_run == 2'd0));

  // R3: the shortest interval is the arm cycle plus one counted cycle
  assert_min_interval_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && stall_w) |-> (run_len >= 8'd2));
endmodule

bind stall_timeout stall_timeout_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tmo_enable   (tmo_enable),
  .xfer_pending (xfer_pending),
  .sink_ready   (sink_ready),
  .timeout_evt  (timeout_evt)
);

// File: tb/stall_timeout_tb_top.sv
`timescale 1ns/1ps
module stall_timeout_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [11:0] pre = 12'd0;
  logic [11:0] cnt = 12'd0;
  logic        pend = 1'b0;
  logic        rdy = 1'b0;
  logic        evt;

  int    vectors = 0;
  int    errors = 0;
  int    cycles = 0;
  string tag = "R1";

  // Reference model state
  bit exp_evt = 1'b0;
  bit m_armed = 1'b0;
  bit m_spent = 1'b0;
  int m_left  = 0;

  always #2 clk = ~clk;

  stall_timeout dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmo_enable   (en),
    .pre_div      (pre),
    .tmo_count    (cnt),
    .xfer_pending (pend),
    .sink_ready   (rdy),
    .timeout_evt  (evt)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      exp_evt = 0; m_armed = 0; m_spent = 0; m_left = 0;
    end else begin
      exp_evt = 0;
      if (!(en && pend && !rdy)) begin
        m_armed = 0; m_spent = 0;
      end else if (!m_armed && !m_spent) begin
        m_armed = 1;
        m_left  = ((cnt == 0) ? 1 : int'(cnt)) * (int'(pre) + 1);
      end else if (m_armed) begin
        m_left--;
        if (m_left == 0) begin
          exp_evt = 1; m_armed = 0; m_spent = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (evt !== exp_evt) begin
      errors++;
      $display("FAIL %s cycle %0d: timeout_evt=%0b expected %0b", tag, cycles, evt, exp_evt);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic drive(input string t, input bit e, input bit p, input bit r, input int n);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = e; pend = p; rdy = r;
    end
  endtask

  task automatic cfg(input logic [11:0] pv, input logic [11:0] cv);
    @(negedge clk);
    pre = pv; cnt = cv;
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive("R1", 0, 0, 0, 4);

    cfg(12'd3, 12'd5);
    drive("R3", 1, 1, 0, 40);
    drive("R3", 1, 1, 1, 3);
    cfg(12'd2, 12'd0);
    drive("R3", 1, 1, 0, 10);
    drive("R3", 1, 0, 0, 2);

    cfg(12'd0, 12'd7);
    drive("R4", 1, 1, 0, 20);
    drive("R4", 1, 0, 1, 2);
    cfg(12'd0, 12'd1);
    drive("R4", 1, 1, 0, 6);
    drive("R4", 0, 1, 0, 2);

    cfg(12'd1, 12'd4);
    drive("R5", 1, 1, 0, 7);
    drive("R5", 1, 1, 1, 1);
    drive("R5", 1, 1, 0, 14);
    drive("R5", 1, 1, 1, 2);

    drive("R6", 1, 1, 0, 7);
    drive("R6", 0, 1, 0, 12);
    drive("R6", 1, 1, 0, 14);
    drive("R6", 0, 0, 1, 2);

    drive("R7", 1, 1, 0, 8);
    drive("R7", 1, 0, 0, 1);
    drive("R7", 1, 1, 0, 14);
    drive("R7", 1, 0, 0, 2);

    cfg(12'd0, 12'd3);
    drive("R8", 1, 1, 0, 60);
    drive("R8", 1, 1, 1, 1);
    drive("R8", 1, 1, 0, 10);
    drive("R8", 1, 0, 0, 2);

    cfg(12'd1, 12'd3);
    drive("R9", 1, 1, 0, 3);
    cfg(12'd5, 12'd9);
    drive("R9", 1, 1, 0, 12);
    drive("R9", 1, 1, 1, 1);
    drive("R9", 1, 1, 0, 70);
    drive("R9", 1, 0, 0, 2);

    cfg(12'd4, 12'd2);
    drive("R2", 1, 1, 1, 30);
    drive("R2", 1, 0, 0, 30);
    drive("R2", 0, 1, 0, 30);

    cfg(12'd0, 12'hFFF);
    drive("R10", 1, 1, 0, 4100);
    drive("R10", 1, 0, 0, 2);
    cfg(12'hFFF, 12'd1);
    drive("R10", 1, 1, 0, 4100);
    drive("R10", 1, 0, 0, 2);
    cfg(12'hFFF, 12'd2);
    drive("R10", 1, 1, 0, 8200);
    drive("R10", 0, 0, 0, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule